// File: doc/BRIEF.md
# Linear Flash Card Byte-Lane and Bank Decoder

This block is the control logic of a removable linear-flash memory card. It takes the host's two active-low byte enables, address bit 0, the read and write strobes and the attribute-plane select. From these it decides which byte lanes of the 16-bit host bus carry data and which 8-bit flash device of which device pair is selected. Each pair holds 1 MB: one 512 KB device for even bytes and one for odd bytes. An 8-bit host reaches the odd byte on the low lane by setting address bit 0 with only the low enable asserted.

Attribute-plane accesses go to a 2 KB configuration memory that holds only even bytes. A write-protect input locks out every write to the flash array. The fitted density is a parameter from 1 to 10 MB. Host addresses wrap at the next power-of-two megabyte boundary, and a wrapped address that lands above the fitted pairs selects nothing.

All decode results are registered once. Chip selects, strobes, flash address, write data and lane enables appear one clock after the host inputs are sampled. Read data is muxed from the selected device onto the host lanes in that same cycle. The data bus is split into an input, an output and a per-lane output enable.

Top module: `card_lane_decoder`

## Requirements
- R1: With both byte enables high (standby) both host lane enables are 0, whatever the other inputs are.
- R2: With only the low enable asserted, one byte travels on host bits 7:0: the even byte when address bit 0 is 0, the odd byte when it is 1. Bits 15:8 are not driven.
- R3: With both enables asserted (word access), address bit 0 is ignored. The even byte is on bits 7:0 and the odd byte on bits 15:8.
- R4: With only the high enable asserted (odd-only access), the odd byte is on bits 15:8 and bits 7:0 are not driven.
- R5: With the attribute select low, the access goes to the configuration memory at byte address bits 11:1, and no flash device is selected. Odd-byte attribute writes are ignored, and odd-byte attribute reads return 8'hFF.
- R6: A read needs the read strobe low and the write strobe high. A write needs the write strobe low and the read strobe high. Any other strobe pair drives no lane and writes nothing.
- R7: Pair p (0 to density-1) is selected when the wrapped address bits 23:20 equal p. Address bits 19:1 go to every device, and at most one device per lane is selected.
- R8: Address bits 23:20 wrap modulo the smallest power of two not below the density; for a 3 MB card, 5 MB reads 1 MB. A wrapped pair index at or above the density selects no device, and reads there return 8'hFF on every driven lane.
- R9: While the write-protect input is high, no flash write occurs; configuration-memory writes are unaffected.
- R10: The wait output is always 1.
- R11: Every result appears on the clock edge after the inputs are sampled. Reset clears all selects, strobes and lane enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_ce_lo_n | input | 1 | Low (even) byte enable, active low |
| host_ce_hi_n | input | 1 | High (odd) byte enable, active low |
| host_oe_n | input | 1 | Read strobe, active low |
| host_we_n | input | 1 | Write strobe, active low |
| host_reg_n | input | 1 | Attribute-plane select, active low |
| host_a | input | 24 | Host byte address |
| host_d_in | input | 16 | Host write data |
| host_d_out | output | 16 | Card read data |
| host_d_oe | output | 2 | Lane drive enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| wait_n | output | 1 | Wait request, active low, held inactive |
| wp_in | input | 1 | Write-protect switch, 1 = protected |
| fl_addr | output | 19 | Address to every flash device |
| fl_cs_even | output | DENSITY_MB | Even-byte device selects, active high, one per pair |
| fl_cs_odd | output | DENSITY_MB | Odd-byte device selects, active high, one per pair |
| fl_oe | output | 1 | Flash read strobe, active high |
| fl_we | output | 1 | Flash write strobe, active high |
| fl_wd_even | output | 8 | Write data to even devices |
| fl_wd_odd | output | 8 | Write data to odd devices |
| fl_rd_even | input | 8 | Read data from the selected even device |
| fl_rd_odd | input | 8 | Read data from the selected odd device |
| cfg_addr | output | 11 | Configuration memory byte address |
| cfg_cs | output | 1 | Configuration memory select |
| cfg_we | output | 1 | Configuration memory write strobe |
| cfg_wd | output | 8 | Configuration memory write data |
| cfg_rd | input | 8 | Configuration memory read data |

## Verification
Selects, strobes and lane enables are due exactly one clock edge after the inputs are applied, and read data follows on the host lanes in that same cycle. The bench applies each host access half a period before an edge and compares the lanes at the next falling edge. Writes reach the device models one edge later than the selects, so a read issued on the following cycle already sees the new byte. The reference model commits its own write only after comparing, which keeps that same ordering.

// File: rtl/card_lane_decoder.sv
module card_lane_decoder #(
  parameter int DENSITY_MB = 3,
  parameter int CFG_AW     = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_ce_lo_n,
  input  logic                  host_ce_hi_n,
  input  logic                  host_oe_n,
  input  logic                  host_we_n,
  input  logic                  host_reg_n,
  input  logic [23:0]           host_a,
  input  logic [15:0]           host_d_in,
  output logic [15:0]           host_d_out,
  output logic [1:0]            host_d_oe,
  output logic                  wait_n,
  input  logic                  wp_in,
  output logic [18:0]           fl_addr,
  output logic [DENSITY_MB-1:0] fl_cs_even,
  output logic [DENSITY_MB-1:0] fl_cs_odd,
  output logic                  fl_oe,
  output logic                  fl_we,
  output logic [7:0]            fl_wd_even,
  output logic [7:0]            fl_wd_odd,
  input  logic [7:0]            fl_rd_even,
  input  logic [7:0]            fl_rd_odd,
  output logic [CFG_AW-1:0]     cfg_addr,
  output logic                  cfg_cs,
  output logic                  cfg_we,
  output logic [7:0]            cfg_wd,
  input  logic [7:0]            cfg_rd
);

  localparam int         WRAP_MB = 1 << $clog2(DENSITY_MB);
  localparam logic [3:0] IDX_MASK = 4'(WRAP_MB - 1);
  localparam logic [4:0] DENS5 = 5'(DENSITY_MB);

  logic en_e, en_o, swap, acc_e, acc_o, rd, wr, attr, populated, fl_go, any_cs;
  logic [3:0] pair_idx;
  logic [DENSITY_MB-1:0] cs_e_nx, cs_o_nx;
  logic r_swap, r_attr, r_hit;

  assign en_e      = ~host_ce_lo_n;
  assign en_o      = ~host_ce_hi_n;
  assign swap      = en_e & ~en_o & host_a[0];
  assign acc_e     = en_e & ~swap;
  assign acc_o     = en_o | swap;
  assign rd        = ~host_oe_n & host_we_n;
  assign wr        = ~host_we_n & host_oe_n;
  assign attr      = ~host_reg_n;
  assign pair_idx  = host_a[23:20] & IDX_MASK;
  assign populated = {1'b0, pair_idx} < DENS5;
  assign fl_go     = ~attr & populated & (rd | (wr & ~wp_in));

  for (genvar p = 0; p < DENSITY_MB; p++) begin : g_pair
    assign cs_e_nx[p] = fl_go & acc_e & (pair_idx == 4'(p));
    assign cs_o_nx[p] = fl_go & acc_o & (pair_idx == 4'(p));
  end

  assign any_cs = |cs_e_nx | |cs_o_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fl_cs_even <= '0;
      fl_cs_odd  <= '0;
      fl_oe      <= 1'b0;
      fl_we      <= 1'b0;
      fl_addr    <= '0;
      fl_wd_even <= '0;
      fl_wd_odd  <= '0;
      cfg_cs     <= 1'b0;
      cfg_we     <= 1'b0;
      cfg_addr   <= '0;
      cfg_wd     <= '0;
      host_d_oe  <= '0;
      r_swap     <= 1'b0;
      r_attr     <= 1'b0;
      r_hit      <= 1'b0;
    end else begin
      fl_cs_even <= cs_e_nx;
      fl_cs_odd  <= cs_o_nx;
      fl_oe      <= any_cs & rd;
      fl_we      <= any_cs & wr;
      fl_addr    <= host_a[19:1];
      fl_wd_even <= host_d_in[7:0];
      fl_wd_odd  <= swap ? host_d_in[7:0] : host_d_in[15:8];
      cfg_cs     <= attr & acc_e & (rd | wr);
      cfg_we     <= attr & acc_e & wr;
      cfg_addr   <= host_a[CFG_AW:1];
      cfg_wd     <= host_d_in[7:0];
      host_d_oe  <= {rd & en_o, rd & en_e};
      r_swap     <= swap;
      r_attr     <= attr;
      r_hit      <= any_cs;
    end
  end

  logic [7:0] fl_lo, fl_hi;
  assign fl_lo = ~r_hit ? 8'hFF : (r_swap ? fl_rd_odd : fl_rd_even);
  assign fl_hi = ~r_hit ? 8'hFF : fl_rd_odd;
  assign host_d_out[7:0]  = r_attr ? (r_swap ? 8'hFF : cfg_rd) : fl_lo;
  assign host_d_out[15:8] = r_attr ? 8'hFF : fl_hi;
  assign wait_n = 1'b1;

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_ce_lo_n & host_ce_hi_n) |-> host_d_oe == 2'b00);
  // R3
  word_both_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(~host_ce_lo_n & ~host_ce_hi_n & ~host_oe_n & host_we_n) |-> host_d_oe == 2'b11);
  // R4
  odd_only_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_ce_lo_n) |-> !host_d_oe[0]);
  // R5
  attr_no_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(~host_reg_n) |-> (fl_cs_even == '0 && fl_cs_odd == '0));
  // R6
  no_strobe_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_oe_n) |-> host_d_oe == 2'b00);
  // R7
  one_dev_per_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fl_cs_even) && $onehot0(fl_cs_odd));
  // R8
  unpop_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, $past(host_a[23:20]) & IDX_MASK} >= DENS5) |-> (fl_cs_even == '0 && fl_cs_odd == '0));
  // R9
  protect_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wp_in) |-> !fl_we);

endmodule

// File: tb/card_lane_decoder_bench.sv
module card_lane_decoder_bench;
  localparam int DENS = 3;
  localparam int CAW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ce_lo_n = 1, ce_hi_n = 1, oe_n = 1, we_n = 1, reg_n = 1, wp = 0;
  logic [23:0] a = '0;
  logic [15:0] d_in = '0;
  logic [15:0] d_out;
  logic [1:0] d_oe;
  logic wait_n;
  logic [18:0] fl_addr;
  logic [DENS-1:0] cs_e, cs_o;
  logic fl_oe, fl_we, cfg_cs, cfg_we;
  logic [7:0] wd_e, wd_o, rd_e, rd_o, cfg_wd, cfg_rd;
  logic [CAW-1:0] cfg_addr;

  card_lane_decoder #(.DENSITY_MB(DENS), .CFG_AW(CAW)) u_card_lane_decoder (
    .clk(clk), .rst_n(rst_n), .host_ce_lo_n(ce_lo_n), .host_ce_hi_n(ce_hi_n),
    .host_oe_n(oe_n), .host_we_n(we_n), .host_reg_n(reg_n), .host_a(a),
    .host_d_in(d_in), .host_d_out(d_out), .host_d_oe(d_oe), .wait_n(wait_n),
    .wp_in(wp), .fl_addr(fl_addr), .fl_cs_even(cs_e), .fl_cs_odd(cs_o),
    .fl_oe(fl_oe), .fl_we(fl_we), .fl_wd_even(wd_e), .fl_wd_odd(wd_o),
    .fl_rd_even(rd_e), .fl_rd_odd(rd_o), .cfg_addr(cfg_addr), .cfg_cs(cfg_cs),
    .cfg_we(cfg_we), .cfg_wd(cfg_wd), .cfg_rd(cfg_rd));

  // Behavioural device arrays driven only by the block's device-side pins.
  logic [7:0] dev_mem [int];
  logic [7:0] cfg_mem [int];
  initial begin rd_e = 8'h00; rd_o = 8'h00; cfg_rd = 8'h00; end
  always @(posedge clk) begin
    if (fl_we)
      for (int p = 0; p < DENS; p++) begin
        if (cs_e[p]) dev_mem[p * 1048576 + int'(fl_addr) * 2] = wd_e;
        if (cs_o[p]) dev_mem[p * 1048576 + int'(fl_addr) * 2 + 1] = wd_o;
      end
    if (cfg_we) cfg_mem[int'(cfg_addr)] = cfg_wd;
    #1;
    rd_e = 8'h00; rd_o = 8'h00; cfg_rd = 8'h00;
    for (int p = 0; p < DENS; p++) begin
      if (cs_e[p]) rd_e = dev_mem.exists(p * 1048576 + int'(fl_addr) * 2) ?
                          dev_mem[p * 1048576 + int'(fl_addr) * 2] : 8'hFF;
      if (cs_o[p]) rd_o = dev_mem.exists(p * 1048576 + int'(fl_addr) * 2 + 1) ?
                          dev_mem[p * 1048576 + int'(fl_addr) * 2 + 1] : 8'hFF;
    end
    if (cfg_cs) cfg_rd = cfg_mem.exists(int'(cfg_addr)) ? cfg_mem[int'(cfg_addr)] : 8'hFF;
  end

  // Reference model: byte-addressed, built from the requirements.
  logic [7:0] ref_fl [int];
  logic [7:0] ref_cfg [int];
  int checks = 0;
  int errors = 0;
  int wrap_mb;

  function automatic int pair_of(logic [23:0] adr);
    return int'(adr[23:20]) % wrap_mb;
  endfunction

  function automatic int fkey(logic [23:0] adr, int lane);
    return pair_of(adr) * 1048576 + int'(adr[19:1]) * 2 + lane;
  endfunction

  function automatic logic [7:0] ref_byte(logic attr, logic [23:0] adr, int lane);
    if (attr) begin
      if (lane == 1) return 8'hFF;
      return ref_cfg.exists(int'(adr[11:1])) ? ref_cfg[int'(adr[11:1])] : 8'hFF;
    end
    if (pair_of(adr) >= DENS) return 8'hFF;
    return ref_fl.exists(fkey(adr, lane)) ? ref_fl[fkey(adr, lane)] : 8'hFF;
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic txn(string tag, logic c1n, logic c2n, logic [23:0] adr,
                     logic oen, logic wen, logic rgn, logic wpv, logic [15:0] dat);
    logic en_e, en_o, rdq, wrq, swp, attr;
    ce_lo_n = c1n; ce_hi_n = c2n; a = adr; oe_n = oen; we_n = wen;
    reg_n = rgn; wp = wpv; d_in = dat;
    @(posedge clk);
    @(negedge clk);
    en_e = !c1n; en_o = !c2n; rdq = !oen && wen; wrq = !wen && oen;
    swp = en_e && !en_o && adr[0]; attr = !rgn;
    chk(tag, "lane enables", {14'd0, d_oe}, {14'd0, rdq && en_o, rdq && en_e});
    chk("R10", "wait", {15'd0, wait_n}, 16'd1);
    if (rdq && en_e)
      chk(tag, "low lane", {8'd0, d_out[7:0]}, {8'd0, ref_byte(attr, adr, swp ? 1 : 0)});
    if (rdq && en_o)
      chk(tag, "high lane", {8'd0, d_out[15:8]}, {8'd0, ref_byte(attr, adr, 1)});
    if (wrq) begin
      if (attr) begin
        if (en_e && !swp) ref_cfg[int'(adr[11:1])] = dat[7:0];
      end else if (!wpv && pair_of(adr) < DENS) begin
        if (en_e && !swp) ref_fl[fkey(adr, 0)] = dat[7:0];
        if (en_o || swp) ref_fl[fkey(adr, 1)] = swp ? dat[7:0] : dat[15:8];
      end
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    wrap_mb = 1;
    while (wrap_mb < DENS) wrap_mb = wrap_mb * 2;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset lane enables", {14'd0, d_oe}, 16'd0);
    chk("R11", "reset selects", {10'd0, cs_o, cs_e}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 word write and read, A0 ignored
    txn("R3", 0, 0, 24'h000100, 1, 0, 1, 0, 16'hA55A);
    txn("R3", 0, 0, 24'h000101, 0, 1, 1, 0, 16'h0000);
    txn("R3", 0, 0, 24'h000202, 1, 0, 1, 0, 16'h1234);
    txn("R3", 0, 0, 24'h000202, 0, 1, 1, 0, 16'h0000);
    // R2 byte writes on the low lane, then reads of both bytes
    txn("R2", 0, 1, 24'h000300, 1, 0, 1, 0, 16'h0011);
    txn("R2", 0, 1, 24'h000301, 1, 0, 1, 0, 16'h0022);
    txn("R2", 0, 1, 24'h000300, 0, 1, 1, 0, 16'h0000);
    txn("R2", 0, 1, 24'h000301, 0, 1, 1, 0, 16'h0000);
    txn("R3", 0, 0, 24'h000300, 0, 1, 1, 0, 16'h0000);
    // R4 odd-only access
    txn("R4", 1, 0, 24'h000400, 1, 0, 1, 0, 16'h77FF);
    txn("R4", 1, 0, 24'h000400, 0, 1, 1, 0, 16'h0000);
    txn("R4", 0, 0, 24'h000400, 0, 1, 1, 0, 16'h0000);
    // R1 standby with read strobe active
    txn("R1", 1, 1, 24'h000100, 0, 1, 1, 0, 16'h0000);
    // R7 distinct pairs at the same offset
    txn("R7", 0, 0, 24'h100500, 1, 0, 1, 0, 16'hBEEF);
    txn("R7", 0, 0, 24'h200500, 1, 0, 1, 0, 16'hCAFE);
    txn("R7", 0, 0, 24'h000500, 0, 1, 1, 0, 16'h0000);
    txn("R7", 0, 0, 24'h100500, 0, 1, 1, 0, 16'h0000);
    txn("R7", 0, 0, 24'h200500, 0, 1, 1, 0, 16'h0000);
    // R8 wrap 5 MB -> 1 MB, unpopulated pair 3
    txn("R8", 0, 0, 24'h500500, 0, 1, 1, 0, 16'h0000);
    txn("R8", 0, 0, 24'h300600, 1, 0, 1, 0, 16'h5678);
    txn("R8", 0, 0, 24'h300600, 0, 1, 1, 0, 16'h0000);
    txn("R8", 0, 0, 24'h700600, 0, 1, 1, 0, 16'h0000);
    // R9 write protect blocks flash writes, not attribute writes
    txn("R9", 0, 0, 24'h000100, 1, 0, 1, 1, 16'h9999);
    txn("R9", 0, 0, 24'h000100, 0, 1, 1, 0, 16'h0000);
    txn("R9", 0, 1, 24'h000010, 1, 0, 0, 1, 16'h00C3);
    txn("R9", 0, 1, 24'h000010, 0, 1, 0, 0, 16'h0000);
    // R5 attribute plane
    txn("R5", 0, 0, 24'h000020, 1, 0, 0, 0, 16'h6644);
    txn("R5", 0, 0, 24'h000020, 0, 1, 0, 0, 16'h0000);
    txn("R5", 0, 1, 24'h000021, 1, 0, 0, 0, 16'h0055);
    txn("R5", 0, 1, 24'h000021, 0, 1, 0, 0, 16'h0000);
    txn("R5", 0, 1, 24'h000020, 0, 1, 0, 0, 16'h0000);
    txn("R5", 0, 0, 24'h000020, 0, 1, 1, 0, 16'h0000);
    // R6 illegal strobe pairs
    txn("R6", 0, 0, 24'h000200, 0, 0, 1, 0, 16'hDEAD);
    txn("R6", 0, 0, 24'h000200, 1, 1, 1, 0, 16'hDEAD);
    txn("R6", 0, 0, 24'h000200, 0, 1, 1, 0, 16'h0000);
    // R7 mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [23:0] ra;
      logic [1:0] st;
      ra = {4'($urandom_range(0, 7)), 8'h00, 11'($urandom_range(0, 15)), 1'($urandom)};
      st = 2'($urandom);
      txn("R7", 1'($urandom), 1'($urandom), ra, st[0] | st[1], ~st[0] | st[1] & st[0],
          ($urandom_range(0, 4) != 0), ($urandom_range(0, 4) == 0), 16'($urandom));
    end
    txn("R11", 1, 1, 24'h0, 1, 1, 1, 0, 16'h0);
    finish_run();
  end
endmodule